// File: doc/BRIEF.md
# Stipple and Blit Pixel Engine

This block is a small drawing accelerator for an 8-bit-per-pixel frame buffer laid out with a pitch of 1024 pixels. Software talks to it through 32-bit register writes on two windows: a stipple window and a blit window. Each command takes two words. A write with word-address bit 2 clear loads a colour holding register. A write with bit 2 set starts an operation. The destination pixel index is carried in the bus address of that trigger write.

A stipple trigger paints the held colour into up to 32 consecutive pixels, chosen by a 32-bit mask. A blit trigger handles runs of 1 to 32 pixels. It fills the run with the held colour when its source field is all ones. Otherwise it copies the run from a source pixel index, in ascending order.

The engine drives a single-port pixel memory one pixel per cycle. Read data from that memory returns one cycle after the read. While the engine works it holds `busy` high. Any further trigger write is stalled by a low `bus_ready` until the operation ends. Colour writes are still accepted during that time.

The sequencer has five states:
- IDLE: waits for a trigger.
- STIPPLE: one mask bit per cycle.
- FILL: one pixel write per cycle.
- COPY_RD: source read.
- COPY_WR: destination write.

The transitions are:
- IDLE goes to STIPPLE, FILL or COPY_RD on an accepted trigger.
- STIPPLE goes back to IDLE after its 32nd cycle.
- FILL goes back to IDLE after its last pixel.
- COPY_RD always goes to COPY_WR.
- COPY_WR goes back to COPY_RD while pixels remain, and to IDLE after the last one.

Top module: `pix_engine`

## Requirements
- R1: Reads from either window return zero, are accepted at once, and cause no pixel access and no busy period.
- R2: A write with `bus_addr[2]`=0 stores `bus_wdata[7:0]` as the held colour; it performs no pixel memory access and does not raise `busy`.
- R3: A write with `bus_addr[2]`=1 starts an operation whose destination pixel index is `bus_addr[22:3]` (20 bits); `bus_win`=0 selects stipple, `bus_win`=1 selects blit.
- R4: A stipple trigger writes the held colour to destination+k for every set bit 31-k of the data (k = 0..31, MSB first); pixels whose bit is clear are left unchanged; `busy` is high for exactly 32 cycles.
- R5: A blit trigger takes its run length as `bus_wdata[28:24]`+1 (1..32) and its source field as `bus_wdata[23:0]`; bits 31:29 have no effect.
- R6: When the blit source field equals 0xFFFFFF, the run of pixels from the destination is filled with the held colour, and `busy` is high for exactly length cycles.
- R7: Otherwise the blit copies the run from source index `bus_wdata[19:0]` to the destination one pixel at a time, reading then writing, in ascending address order (so overlapping runs see that order); `busy` is high for 2*length cycles.
- R8: A trigger write presented while `busy` is high sees `bus_ready`=0 until the engine returns to idle, and is then accepted and executed.
- R9: A colour write is accepted while busy, but the operation in progress keeps the colour held when it was triggered; the new colour is used by the next operation.
- R10: After reset the engine is idle: `busy`=0, `bus_ready`=1 and `mem_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | Window select: 0 stipple, 1 blit |
| bus_addr | input | 21 | Word address, bits 22:2 of the byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| bus_ready | output | 1 | Access accepted on a clock edge where req and ready are both high |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Pixel memory access enable |
| mem_we | output | 1 | Pixel memory write (with mem_en) |
| mem_addr | output | 20 | Pixel index |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data, valid the cycle after a read |

## Verification
A wrong pixel index or a bad mask shift shows up as a wrong or extra pixel in the memory image. The bench compares the whole image after every operation, so such an error is seen at the end of the operation that caused it. A wrong loop bound or state transition changes the number of cycles `busy` stays high, and that count is checked for every operation. A colour latched at the wrong moment shows as a wrong pixel value in the overlapped-write case. A broken ready qualification shows as an immediate change in the counted stall cycles.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
    localparam int PIX_AW  = 20;
    localparam int RUN_W   = 5;
    localparam int MASK_W  = 32;
    localparam int PIX_W   = 8;

    typedef enum logic [1:0] {
        OP_STIPPLE = 2'd0,
        OP_FILL    = 2'd1,
        OP_COPY    = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_STIPPLE = 3'd1,
        S_FILL    = 3'd2,
        S_COPY_RD = 3'd3,
        S_COPY_WR = 3'd4
    } state_e;

    typedef struct packed {
        op_e                op;
        logic [PIX_AW-1:0]  dst;
        logic [PIX_AW-1:0]  src;
        logic [RUN_W-1:0]   last;
        logic [MASK_W-1:0]  mask;
    } cmd_t;
endpackage

// File: rtl/pxe_decode.sv
module pxe_decode
    import pxe_pkg::*;
#(
    parameter int BUS_AW = PIX_AW + 3
) (
    input  logic              win,
    input  logic [BUS_AW-1:2] addr,
    input  logic [31:0]       wdata,
    output cmd_t              cmd
);
    localparam logic [23:0] FILL_KEY = 24'hFF_FFFF;

    always_comb begin
        cmd.dst  = addr[PIX_AW+2:3];
        cmd.src  = wdata[PIX_AW-1:0];
        cmd.last = wdata[24 +: RUN_W];
        cmd.mask = wdata;
        if (!win) begin
            cmd.op = OP_STIPPLE;
        end else if (wdata[23:0] == FILL_KEY) begin
            cmd.op = OP_FILL;
        end else begin
            cmd.op = OP_COPY;
        end
    end
endmodule

// File: rtl/pxe_colour.sv
module pxe_colour
    import pxe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/pxe_seq.sv
module pxe_seq
    import pxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [PIX_W-1:0]  colour,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata
);
    localparam logic [RUN_W-1:0] STIP_LAST = RUN_W'(MASK_W - 1);

    state_e             state_q, state_d;
    logic [PIX_AW-1:0]  dst_q, src_q;
    logic [RUN_W-1:0]   idx_q, last_q;
    logic [MASK_W-1:0]  mask_q;
    logic [PIX_W-1:0]   col_q;
    logic               step;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    unique case (cmd.op)
                        OP_STIPPLE: state_d = S_STIPPLE;
                        OP_FILL:    state_d = S_FILL;
                        default:    state_d = S_COPY_RD;
                    endcase
                end
            end
            S_STIPPLE: if (idx_q == STIP_LAST) state_d = S_IDLE;
            S_FILL:    if (idx_q == last_q)    state_d = S_IDLE;
            S_COPY_RD: state_d = S_COPY_WR;
            S_COPY_WR: state_d = (idx_q == last_q) ? S_IDLE : S_COPY_RD;
            default:   state_d = S_IDLE;
        endcase
    end

    assign step = (state_q == S_STIPPLE) || (state_q == S_FILL) ||
                  (state_q == S_COPY_WR);

    // State register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dst_q   <= '0;
            src_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            mask_q  <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                dst_q  <= cmd.dst;
                src_q  <= cmd.src;
                last_q <= cmd.last;
                mask_q <= cmd.mask;
                col_q  <= colour;
                idx_q  <= '0;
            end else if (step) begin
                idx_q  <= idx_q + 1'b1;
                mask_q <= mask_q << 1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_q + PIX_AW'(idx_q);
        mem_wdata = col_q;
        unique case (state_q)
            S_IDLE: ;
            S_STIPPLE: begin
                mem_en = mask_q[MASK_W-1];
                mem_we = 1'b1;
            end
            S_FILL: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            S_COPY_RD: begin
                mem_en   = 1'b1;
                mem_addr = src_q + PIX_AW'(idx_q);
            end
            S_COPY_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pix_engine.sv
module pix_engine
    import pxe_pkg::*;
#(
    parameter int BUS_AW = PIX_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [BUS_AW-1:2] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [PIX_AW-1:0] mem_addr,
    output logic [PIX_W-1:0]  mem_wdata,
    input  logic [PIX_W-1:0]  mem_rdata
);
    cmd_t             cmd;
    logic [PIX_W-1:0] colour;
    logic             is_trig, start, col_load;

    assign is_trig   = bus_we && bus_addr[2];
    assign bus_ready = !(busy && is_trig);
    assign start     = bus_req && is_trig && bus_ready;
    assign col_load  = bus_req && bus_we && !bus_addr[2];
    assign bus_rdata = '0;

    pxe_decode #(.BUS_AW(BUS_AW)) dec_i (
        .win   (bus_win),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    pxe_colour col_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (col_load),
        .din   (bus_wdata[PIX_W-1:0]),
        .q     (colour)
    );

    pxe_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (cmd),
        .colour    (colour),
        .busy      (busy),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );
endmodule

// File: rtl/pxe_checker.sv
module pxe_checker
    import pxe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ready,
    input logic [22:2]       bus_addr,
    input logic              busy,
    input logic              mem_en,
    input logic              mem_we,
    input logic [PIX_AW-1:0] mem_addr
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // R8
    trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && bus_we && bus_addr[2] && !busy) |=> busy);

    // R7
    copy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (mem_en && mem_we));

    // R4
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && $past(mem_en && mem_we)) |->
            (mem_addr == $past(mem_addr) + 1'b1));

    // R8
    ready_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bus_ready);
endmodule

bind pix_engine pxe_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .busy      (busy),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/pix_engine_tb.sv
module pix_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MSZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
    logic [22:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ready, busy, mem_en, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  mem [MSZ];
    logic [7:0]  expm [MSZ];
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .busy(busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = -1;
        for (int i = 0; i < MSZ; i++)
            if (bad < 0 && mem[i] !== expm[i]) bad = i;
        if (bad >= 0) chk(1'b0, req, {bad, 8'h0, mem[bad]}, {bad, 8'h0, expm[bad]});
        else          chk(1'b1, req, 0, 0);
    endtask

    // Drive one access; returns after acceptance, at the following negedge.
    task automatic bus_put(input bit win, input bit we, input logic [22:2] a,
                           input logic [31:0] d, output int stalls, output logic [31:0] rd);
        stalls = 0;
        bus_req = 1'b1; bus_we = we; bus_win = win; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [22:2] trig_addr(input int dst);
        return {dst[19:0], 1'b1};
    endfunction

    task automatic set_col(input logic [7:0] c);
        int s; logic [31:0] r;
        bus_put(1'b0, 1'b1, '0, {24'hABCDE0, c}, s, r);
    endtask

    task automatic do_stip(input int dst, input logic [31:0] m, input logic [7:0] c);
        int s, n; logic [31:0] r;
        set_col(c);
        bus_put(1'b0, 1'b1, trig_addr(dst), m, s, r);
        wait_idle(n);
        for (int k = 0; k < 32; k++) if (m[31-k]) expm[dst+k] = c;
        chk(n == 32, "R4 stipple busy cycles", n, 32);
        chk_mem("R4 stipple image");
    endtask

    task automatic do_fill(input int dst, input int len, input logic [2:0] top, input logic [7:0] c);
        int s, n; logic [31:0] r; logic [4:0] l;
        l = 5'(len - 1);
        set_col(c);
        bus_put(1'b1, 1'b1, trig_addr(dst), {top, l, 24'hFFFFFF}, s, r);
        wait_idle(n);
        for (int k = 0; k < len; k++) expm[dst+k] = c;
        chk(n == len, "R6 fill busy cycles", n, len);
        chk_mem("R5 R6 fill image");
    endtask

    task automatic do_copy(input int dst, input int src, input int len, input logic [3:0] hi);
        int s, n; logic [31:0] r; logic [4:0] l;
        l = 5'(len - 1);
        bus_put(1'b1, 1'b1, trig_addr(dst), {3'b000, l, hi, src[19:0]}, s, r);
        wait_idle(n);
        for (int k = 0; k < len; k++) expm[dst+k] = expm[src+k];
        chk(n == 2*len, "R7 copy busy cycles", n, 2*len);
        chk_mem("R7 copy image");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s, n;
        logic [31:0] r;
        for (int i = 0; i < MSZ; i++) begin
            mem[i]  = 8'((i * 7 + 3) & 8'hFF);
            expm[i] = 8'((i * 7 + 3) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk(busy == 1'b0, "R10 busy after reset", busy, 0);
        chk(bus_ready == 1'b1, "R10 ready after reset", bus_ready, 1);
        chk(mem_en == 1'b0, "R10 mem_en after reset", mem_en, 0);

        // R1 reads in both windows, both bit-2 settings
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 2; b++) begin
                bus_put(w[0], 1'b0, {20'd300, b[0]}, 32'hFFFFFFFF, s, r);
                chk(r == 32'd0 && s == 0, "R1 read data", r, 0);
                chk(busy == 1'b0, "R1 read no busy", busy, 0);
            end
        end
        chk_mem("R1 read no pixel change");

        // R2 colour write alone
        set_col(8'h5A);
        chk(busy == 1'b0, "R2 colour write no busy", busy, 0);
        chk_mem("R2 colour write no pixel change");

        // R3 R4 stipple sweeps: walking bit, then patterns
        for (int k = 0; k < 32; k++)
            do_stip(64 + k * 37, 32'h1 << k, 8'(k * 9 + 1));
        do_stip(1300, 32'hFFFFFFFF, 8'hC3);
        do_stip(1340, 32'h00000000, 8'h3C);
        do_stip(1380, 32'hA5A5A5A5, 8'h77);
        do_stip(1420, 32'h80000001, 8'hEE);

        // R5 R6 fill sweep over every length
        for (int len = 1; len <= 32; len++)
            do_fill(1500 + len * 40, len, (len % 2) ? 3'b101 : 3'b000, 8'(len + 100));

        // R7 copy sweep, source bits 23:20 not all ones
        for (int len = 1; len <= 32; len++)
            do_copy(2900 + len * 30, 100 + len * 3, len, 4'(len % 15));
        do_copy(3990, 3989, 8, 4'h0);   // overlap, dst above src
        do_copy(3960, 3962, 8, 4'h0);   // overlap, dst below src

        // R8 trigger while busy stalls for the whole stipple
        set_col(8'h11);
        bus_put(1'b0, 1'b1, trig_addr(40), 32'hFFFFFFFF, s, r);
        for (int k = 0; k < 32; k++) expm[40+k] = 8'h11;
        bus_put(1'b1, 1'b1, trig_addr(30), {3'b0, 5'd3, 24'hFFFFFF}, s, r);
        chk(s == 32, "R8 stall cycles", s, 32);
        wait_idle(n);
        for (int k = 0; k < 4; k++) expm[30+k] = 8'h11;
        chk(n == 4, "R8 stalled fill runs", n, 4);
        chk_mem("R8 image after stall");

        // R9 colour change during an operation
        set_col(8'h21);
        bus_put(1'b0, 1'b1, trig_addr(3000), 32'hFFFF0000, s, r);
        bus_put(1'b0, 1'b1, '0, 32'h00000042, s, r);
        chk(s == 0, "R9 colour write accepted while busy", s, 0);
        chk(busy == 1'b1, "R9 operation still running", busy, 1);
        wait_idle(n);
        for (int k = 0; k < 16; k++) expm[3000+k] = 8'h21;
        chk_mem("R9 running op kept old colour");
        bus_put(1'b1, 1'b1, trig_addr(3050), {3'b0, 5'd1, 24'hFFFFFF}, s, r);
        wait_idle(n);
        expm[3050] = 8'h42; expm[3051] = 8'h42;
        chk_mem("R9 next op uses new colour");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule